// File: doc/BRIEF.md
# Inter-Processor Doorbell Register Pair

This block lets one processor raise a notification for another through two memory-mapped 32-bit registers. Both registers look at one shared vector of source flags. One register is the raise view: a 1 written to a flag position sets that flag. The other is the acknowledge view: a 1 written to a flag position clears it. A 0 written to a flag position in either view leaves that flag as it is. Bit 0 of the raise view is a strobe with no storage behind it. Writing 1 to it drives the interrupt output high for exactly one clock cycle.

A sender writes ones to its own flag positions and sets the strobe, either in that write or in a later one. The receiver takes the interrupt, reads either register to see which sources are pending, and writes those bits back to the acknowledge view. The flag vector is also available directly on an output port. Read data is registered and holds its value until the next read.

Top module: `ipc_doorbell`

## Requirements
- R1: After reset is asserted, the flag vector is all zero, the interrupt output is low and the read data is zero.
- R2: A write to the raise address (offset 0x00) sets every flag whose bit (31..4) is 1 in the write data. Flags whose bit is 0 keep their value.
- R3: A write to the acknowledge address (offset 0x04) clears every flag whose bit (31..4) is 1 in the write data. Flags whose bit is 0 keep their value.
- R4: A read of either register address returns the flag vector in bits 31..4 and zeros in bits 3..0, including bit 0 of the raise view. The data appears on the read port after the clock edge that takes the read request. When a write arrives in the same cycle, the read returns the flags as they were before that write.
- R5: A raise-view write with bit 0 set makes the interrupt output high for the single cycle after the write edge.
- R6: The strobe is not stored. Strobe writes on consecutive cycles give one high cycle each. The output is low after any cycle that carries no strobe write.
- R7: A write to any address other than the two register addresses changes nothing, and a read of such an address returns zero.
- R8: The flag output port shows the flag vector, updated at the edge that takes the write.
- R9: A single raise-view write that carries both flag bits and the strobe bit sets the flags and pulses the interrupt at the same edge.
- R10: Bits 3..0 of an acknowledge-view write have no effect. In particular, bit 0 there produces no interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write request |
| bus_rd_i | input | 1 | Read request |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_pulse_o | output | 1 | One-cycle interrupt pulse |
| flags_o | output | 28 | Current source flag vector |

## Verification
Two functions can fall in one cycle: setting flags and firing the strobe in a single raise-view write, and a read together with a write. The bench drives a raise-view write that carries both flag bits and bit 0. It expects the new flags and a high interrupt output at the same edge. The bench also asserts the read and write strobes together. It expects the read data to show the flag vector from before the write, while the flag port already shows the value after it.

// File: rtl/ipc_doorbell_pkg.sv
package ipc_doorbell_pkg;

   // Which register a bus address points at
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_RAISE = 2'd1,
      SEL_ACK = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/ipc_addr_decode.sv
module ipc_addr_decode
   import ipc_doorbell_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] RAISE_OFFS = '0,
   parameter logic [ADDR_W-1:0] ACK_OFFS = ADDR_W'(4)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);

   initial begin
      if (RAISE_OFFS == ACK_OFFS)
         $error("ipc_addr_decode: both registers share one offset");
   end

   always_comb begin
      if (addr_i == RAISE_OFFS)
         sel_o = SEL_RAISE;
      else if (addr_i == ACK_OFFS)
         sel_o = SEL_ACK;
      else
         sel_o = SEL_NONE;
   end

endmodule

// File: rtl/ipc_flag_bank.sv
module ipc_flag_bank #(
   parameter int NUM_SRC = 28
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] flags_o
);

   initial begin
      if (NUM_SRC < 1)
         $error("ipc_flag_bank: NUM_SRC must be at least 1");
   end

   // One storage cell per source; a set wins over a clear that lands in the same cycle
   for (genvar b = 0; b < NUM_SRC; b++) begin : g_cell
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            flags_o[b] <= 1'b0;
         else if (set_i[b])
            flags_o[b] <= 1'b1;
         else if (clr_i[b])
            flags_o[b] <= 1'b0;
      end
   end

   // R2: raised bits read as set afterwards
   a_r2_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

   // R3: acknowledged bits (not raised at the same time) read as clear afterwards
   a_r3_clear_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

   // R2/R3: a bit touched by neither port keeps its value
   a_r2_r3_untouched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((set_i | clr_i) == '0) |=> $stable(flags_o));

endmodule

// File: rtl/ipc_strobe_gen.sv
module ipc_strobe_gen (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fire_i,
   output logic pulse_o
);

   // No storage beyond one cycle: each fire gives exactly one high cycle
   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         pulse_o <= 1'b0;
      else
         pulse_o <= fire_i;
   end

endmodule

// File: rtl/ipc_read_port.sv
module ipc_read_port
   import ipc_doorbell_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int FLAG_LSB = 4,
   parameter int READ_LAT = 1,
   localparam int NUM_SRC = DATA_W - FLAG_LSB
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               rd_i,
   input  reg_sel_e           sel_i,
   input  logic [NUM_SRC-1:0] flags_i,
   output logic [DATA_W-1:0]  rdata_o
);

   logic [DATA_W-1:0] view;

   initial begin
      if (READ_LAT != 0 && READ_LAT != 1)
         $error("ipc_read_port: READ_LAT must be 0 or 1");
   end

   // Both mapped registers show the same flags; the low bits always read as zero
   always_comb begin
      if (sel_i == SEL_NONE)
         view = '0;
      else
         view = {flags_i, {FLAG_LSB{1'b0}}};
   end

   if (READ_LAT == 1) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            rdata_o <= '0;
         else if (rd_i)
            rdata_o <= view;
      end

      // R4: read data holds between reads
      a_r4_hold_between_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !rd_i |=> $stable(rdata_o));

      // R7: an unmapped read returns zero
      a_r7_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rd_i && sel_i == SEL_NONE) |=> (rdata_o == '0));

      // R4: the reserved low field never reads as one
      a_r4_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
         rdata_o[FLAG_LSB-1:0] == '0);
   end else begin : g_comb
      assign rdata_o = rd_i ? view : '0;
   end

endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
   import ipc_doorbell_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int FLAG_LSB = 4,
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] RAISE_OFFS = '0,
   parameter logic [ADDR_W-1:0] ACK_OFFS = ADDR_W'(4),
   parameter int READ_LAT = 1,
   localparam int NUM_SRC = DATA_W - FLAG_LSB
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               bus_wr_i,
   input  logic               bus_rd_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               irq_pulse_o,
   output logic [NUM_SRC-1:0] flags_o
);

   reg_sel_e           sel;
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic               fire;

   initial begin
      if (FLAG_LSB < 1 || FLAG_LSB >= DATA_W)
         $error("ipc_doorbell: FLAG_LSB must leave room for the strobe and one flag");
   end

   ipc_addr_decode #(
      .ADDR_W    (ADDR_W),
      .RAISE_OFFS(RAISE_OFFS),
      .ACK_OFFS  (ACK_OFFS)
   ) i_decode (
      .addr_i(bus_addr_i),
      .sel_o (sel)
   );

   assign set_vec = (bus_wr_i && sel == SEL_RAISE) ? bus_wdata_i[DATA_W-1:FLAG_LSB] : '0;
   assign clr_vec = (bus_wr_i && sel == SEL_ACK) ? bus_wdata_i[DATA_W-1:FLAG_LSB] : '0;
   assign fire    = bus_wr_i && sel == SEL_RAISE && bus_wdata_i[0];

   ipc_flag_bank #(
      .NUM_SRC(NUM_SRC)
   ) i_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .flags_o(flags_o)
   );

   ipc_strobe_gen i_strobe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (fire),
      .pulse_o(irq_pulse_o)
   );

   ipc_read_port #(
      .DATA_W  (DATA_W),
      .FLAG_LSB(FLAG_LSB),
      .READ_LAT(READ_LAT)
   ) i_read (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rd_i   (bus_rd_i),
      .sel_i  (sel),
      .flags_i(flags_o),
      .rdata_o(bus_rdata_o)
   );

   // R8: without a write the flag port does not move
   a_r8_flags_need_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_wr_i |=> $stable(flags_o));

   // R5: every high pulse cycle traces back to a raise-view strobe write
   a_r5_pulse_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_pulse_o |-> $past(bus_wr_i && bus_addr_i == RAISE_OFFS && bus_wdata_i[0]));

   // R6: a pulse does not outlive its cause
   a_r6_no_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_pulse_o && !(bus_wr_i && bus_addr_i == RAISE_OFFS && bus_wdata_i[0]))
      |=> !irq_pulse_o);

   // R10: the low field of an acknowledge write never fires the interrupt
   a_r10_ack_low_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == ACK_OFFS && bus_wdata_i[FLAG_LSB-1:0] != '0)
      |=> !irq_pulse_o);

   // R7: writes to an unmapped offset change no flag
   a_r7_unmapped_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i != RAISE_OFFS && bus_addr_i != ACK_OFFS) |=> $stable(flags_o));

endmodule

// File: tb/test_ipc_doorbell.sv
module test_ipc_doorbell;

   typedef struct packed {
      logic        wr;
      logic        rd;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp_view; // expected flags, shown at bits 31..4
      logic        exp_irq;
      logic [31:0] exp_rdata;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 8'h00, 32'hA000_0010, 32'hA000_0010, 1'b0, 32'h0, 4'd2},  // R2 set
      '{1'b0, 1'b1, 8'h00, 32'h0,         32'hA000_0010, 1'b0, 32'hA000_0010, 4'd4}, // R4 raise view
      '{1'b1, 1'b0, 8'h00, 32'h0000_0001, 32'hA000_0010, 1'b1, 32'hA000_0010, 4'd5}, // R5 strobe
      '{1'b1, 1'b0, 8'h00, 32'h0000_0001, 32'hA000_0010, 1'b1, 32'hA000_0010, 4'd6}, // R6 back to back
      '{1'b0, 1'b1, 8'h04, 32'h0,         32'hA000_0010, 1'b0, 32'hA000_0010, 4'd4}, // R4 ack view
      '{1'b1, 1'b0, 8'h04, 32'h8000_000F, 32'h2000_0010, 1'b0, 32'hA000_0010, 4'd10}, // R10 R3
      '{1'b1, 1'b0, 8'h00, 32'h0F00_0001, 32'h2F00_0010, 1'b1, 32'hA000_0010, 4'd9}, // R9
      '{1'b1, 1'b0, 8'h08, 32'hFFFF_FFFF, 32'h2F00_0010, 1'b0, 32'hA000_0010, 4'd7}, // R7 write
      '{1'b0, 1'b1, 8'h08, 32'h0,         32'h2F00_0010, 1'b0, 32'h0,         4'd7}, // R7 read
      '{1'b1, 1'b0, 8'h04, 32'h0,         32'h2F00_0010, 1'b0, 32'h0,         4'd3}, // R3 zeros
      '{1'b1, 1'b0, 8'h00, 32'h0,         32'h2F00_0010, 1'b0, 32'h0,         4'd2}, // R2 zeros
      '{1'b0, 1'b1, 8'h00, 32'h0,         32'h2F00_0010, 1'b0, 32'h2F00_0010, 4'd8}, // R8
      '{1'b1, 1'b0, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 1'b1, 32'h2F00_0010, 4'd4}, // R4 all set
      '{1'b0, 1'b1, 8'h00, 32'h0,         32'hFFFF_FFF0, 1'b0, 32'hFFFF_FFF0, 4'd4}, // R4 bit0 reads 0
      '{1'b1, 1'b0, 8'h04, 32'hFFFF_FFF0, 32'h0,         1'b0, 32'hFFFF_FFF0, 4'd3}  // R3 clear all
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic [27:0] flags;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   ipc_doorbell i_ipc_doorbell (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .bus_wr_i   (wr),
      .bus_rd_i   (rd),
      .bus_addr_i (addr),
      .bus_wdata_i(wdata),
      .bus_rdata_o(rdata),
      .irq_pulse_o(irq),
      .flags_o    (flags)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive at falling edge, let one rising edge pass, sample just after it
   task automatic step(logic w, logic r, logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr = w; rd = r; addr = a; wdata = d;
      @(posedge clk);
      #1;
      wr = 1'b0; rd = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      @(posedge clk);
      #1;
      check("R1 flags", {4'h0, flags}, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      check("R1 rdata", rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].data);
         check($sformatf("R%0d/R8 flags vec%0d", VECS[i].req, i),
               {flags, 4'h0}, VECS[i].exp_view);
         check($sformatf("R%0d irq vec%0d", VECS[i].req, i),
               {31'h0, irq}, {31'h0, VECS[i].exp_irq});
         check($sformatf("R%0d rdata vec%0d", VECS[i].req, i),
               rdata, VECS[i].exp_rdata);
      end

      // R6: the cycle after a strobe with no new strobe is low
      step(1'b0, 1'b0, 8'h00, 32'h0);
      check("R6 idle after strobe", {31'h0, irq}, 32'h0);

      // R4: read and write together return the pre-write flags
      step(1'b1, 1'b0, 8'h00, 32'h0000_0100);
      check("R2 setup", {flags, 4'h0}, 32'h0000_0100);
      step(1'b1, 1'b1, 8'h00, 32'h0000_1001);
      check("R4 read with write old value", rdata, 32'h0000_0100);
      check("R9 flags with strobe", {flags, 4'h0}, 32'h0000_1100);
      check("R9 irq with set", {31'h0, irq}, 32'h1);
      step(1'b1, 1'b1, 8'h04, 32'h0000_0100);
      check("R4 read with ack old value", rdata, 32'h0000_1100);
      check("R3 ack single", {flags, 4'h0}, 32'h0000_1000);

      // R10: ack write with only the low field changes nothing
      step(1'b1, 1'b0, 8'h04, 32'h0000_0001);
      check("R10 no pulse", {31'h0, irq}, 32'h0);
      check("R10 flags kept", {flags, 4'h0}, 32'h0000_1000);

      // R1: reset in mid-run clears state
      step(1'b1, 1'b1, 8'h00, 32'hF000_0001);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("R1 flags after rerun reset", {4'h0, flags}, 32'h0);
      check("R1 irq after rerun reset", {31'h0, irq}, 32'h0);
      check("R1 rdata after rerun reset", rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b1, 8'h04, 32'h0);
      check("R4 read after reset", rdata, 32'h0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule